// File: doc/BRIEF.md
# Host Port Interface Write Sequencer

This block loads a block of 16-bit words into a DSP's host port over an asynchronous, non-multiplexed 16-bit parallel bus. A single start command carries a 32-bit target word address, a word count, the control-register value and two strobe timing values. The data words then arrive on a valid/ready stream. The sequencer turns the command into a fixed series of bus writes. Only bits [2:1] of the bus address reach the DSP, as its two register-select lines, so each DSP register sits at its own fixed bus address.

The phase sequencer has these states: `PH_IDLE`, `PH_CTRL_HI`, `PH_ADDR_HI`, `PH_CTRL_LO`, `PH_ADDR_LO`, `PH_DATA_WAIT`, `PH_DATA_BUS` and `PH_DONE`.
- An accepted start moves `PH_IDLE` to `PH_CTRL_HI`.
- Each write state moves to the next one when its bus cycle reports completion: `PH_CTRL_HI` to `PH_ADDR_HI`, to `PH_CTRL_LO`, to `PH_ADDR_LO`, to `PH_DATA_WAIT`.
- A stream handshake moves `PH_DATA_WAIT` to `PH_DATA_BUS`.
- A completed data write moves `PH_DATA_BUS` back to `PH_DATA_WAIT`, or to `PH_DONE` if it was the last word.
- `PH_DONE` always returns to `PH_IDLE`.

The bus-cycle engine runs every write through `BC_IDLE`, then `BC_SETUP` (setup count), `BC_STROBE` (pulse count), `BC_HOLD` (one cycle), and back to `BC_IDLE`.

Top module: `hpi_write_seq`

## Requirements
- R1: While reset is held, and after it is released, `cs_n_o` and `we_n_o` are 1, and `busy_o`, `done_o` and `in_ready_o` are 0.
- R2: The bus address is {sel1, sel0, 0}. The control register uses select 00 (address 3'b000). The address register uses select sel1=1, sel0=0 (address 3'b100). The auto-increment data register uses select sel1=0, sel0=1 (address 3'b010). Bit 0 is always 0.
- R3: An accepted command first issues exactly these four writes, in this order: control word, address bits [31:16], control word, address bits [15:0].
- R4: After those four writes, exactly `count` writes follow. All of them go to the data register, the words keep their stream order, and no address write occurs between them.
- R5: The control word, target address, count and timing values are captured in the cycle the start is accepted. Later changes on those inputs have no effect on the sequence in progress.
- R6: Bus address and data are driven max(setup,1) cycles before the strobe falls. Counted over busy cycles, the first write of a sequence has max(setup,1)+1 strobe-high cycles before it. When the stream is not stalled, later writes have max(setup,1)+2.
- R7: `cs_n_o` and `we_n_o` stay low together for exactly max(pulse,1) cycles. Address and data do not change while they are low.
- R8: For one cycle after the strobe rises, address and data keep the values they had during the strobe.
- R9: `done_o` is high for exactly one cycle, after the hold cycle of the last data write. `busy_o` is low in the following cycle.
- R10: A start raised while `busy_o` is high is ignored. The bus writes are the same as if it had not occurred.
- R11: A start with a count of zero is ignored: `busy_o` stays low and no bus write occurs.
- R12: `in_ready_o` is high only in the data phase while no bus cycle is running. Each handshake produces exactly one data write, and stalls on `in_valid_i` are tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start command pulse |
| start_addr_i | input | 32 | Target word address in DSP memory |
| start_count_i | input | 16 | Number of data words, zero means no transfer |
| ctrl_word_i | input | 16 | Value written to the control register |
| setup_cyc_i | input | 4 | Setup cycles before the strobe (0 acts as 1) |
| pulse_cyc_i | input | 4 | Strobe low cycles (0 acts as 1) |
| in_data_i | input | 16 | Data word stream |
| in_valid_i | input | 1 | Stream word valid |
| in_ready_o | output | 1 | Stream word accepted when high with valid |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| bus_addr_o | output | 3 | Bus address bits [2:0], bits [2:1] select the register |
| bus_data_o | output | 16 | Bus write data |
| cs_n_o | output | 1 | Active-low chip select |
| we_n_o | output | 1 | Active-low write strobe |

## Verification
A wrong phase state appears directly in the recorded series of bus writes. A skipped or repeated phase gives a wrong select code or a wrong half of the address at a known position in the write log, at the latest by the end of the fifth strobe. A wrong timing counter appears in the strobe-low run or the strobe-high gap of the very first write, within a few cycles of the start. A bad word counter makes the data-write count differ from the request and moves the done pulse. An unguarded start changes the address words written during the run in which it occurs.

// File: rtl/hpi_seq_pkg.sv
package hpi_seq_pkg;

    // Register select codes as {sel1, sel0}, placed on bus address bits [2:1]
    localparam logic [1:0] SEL_CTRL     = 2'b00;
    localparam logic [1:0] SEL_DATA_INC = 2'b01;
    localparam logic [1:0] SEL_ADDR     = 2'b10;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_SETUP,
        BC_STROBE,
        BC_HOLD
    } bc_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL_HI,
        PH_ADDR_HI,
        PH_CTRL_LO,
        PH_ADDR_LO,
        PH_DATA_WAIT,
        PH_DATA_BUS,
        PH_DONE
    } ph_state_e;

endpackage

// File: rtl/hpi_bus_cycle.sv
module hpi_bus_cycle
    import hpi_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [TIME_W-1:0] setup_cyc_i,
    input  logic [TIME_W-1:0] pulse_cyc_i,
    output logic [2:0]        bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              cs_n_o,
    output logic              we_n_o,
    output logic              idle_o,
    output logic              cyc_done_o
);

    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    bc_state_e         state_q, state_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic [2:0]        addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic [TIME_W-1:0] eff_setup, eff_pulse;

    assign eff_setup = (setup_cyc_i == '0) ? ONE : setup_cyc_i;
    assign eff_pulse = (pulse_cyc_i == '0) ? ONE : pulse_cyc_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        data_d  = data_q;
        unique case (state_q)
            BC_IDLE: begin
                if (go_i) begin
                    state_d = BC_SETUP;
                    cnt_d   = eff_setup;
                    addr_d  = {sel_i, 1'b0};
                    data_d  = wdata_i;
                end
            end
            BC_SETUP: begin
                if (cnt_q == ONE) begin
                    state_d = BC_STROBE;
                    cnt_d   = eff_pulse;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            BC_STROBE: begin
                if (cnt_q == ONE) state_d = BC_HOLD;
                else              cnt_d   = cnt_q - ONE;
            end
            BC_HOLD: state_d = BC_IDLE;
            default: state_d = BC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BC_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
        end
    end

    // Outputs
    always_comb begin
        bus_addr_o = addr_q;
        bus_data_o = data_q;
        cs_n_o     = (state_q != BC_STROBE);
        we_n_o     = (state_q != BC_STROBE);
        idle_o     = (state_q == BC_IDLE);
        cyc_done_o = (state_q == BC_HOLD);
    end

    // Checker counters for the timing windows
    logic [TIME_W-1:0] setup_run_q, strobe_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_run_q  <= '0;
            strobe_run_q <= '0;
        end else begin
            if (state_q == BC_SETUP)       setup_run_q <= setup_run_q + ONE;
            else if (state_q == BC_IDLE)   setup_run_q <= '0;
            if (state_q == BC_STROBE)      strobe_run_q <= strobe_run_q + ONE;
            else if (state_q == BC_SETUP)  strobe_run_q <= '0;
        end
    end

    assert_setup_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BC_STROBE && $past(state_q) == BC_SETUP) |-> (setup_run_q == eff_setup));

    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BC_HOLD) |-> (strobe_run_q == eff_pulse));

    assert_strobe_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o && $past(!we_n_o)) |-> ($stable(bus_addr_o) && $stable(bus_data_o)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> ($stable(bus_addr_o) && $stable(bus_data_o) && cs_n_o));

endmodule

// File: rtl/hpi_phase_seq.sv
module hpi_phase_seq
    import hpi_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  start_count_i,
    input  logic [DATA_W-1:0] ctrl_word_i,
    input  logic [TIME_W-1:0] setup_cyc_i,
    input  logic [TIME_W-1:0] pulse_cyc_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              busy_o,
    output logic              done_o,
    input  logic              eng_idle_i,
    input  logic              eng_done_i,
    output logic              go_o,
    output logic [1:0]        sel_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [TIME_W-1:0] setup_o,
    output logic [TIME_W-1:0] pulse_o
);

    localparam int HALF_W = ADDR_W / 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ph_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [TIME_W-1:0] setup_q, pulse_q;
    logic [CNT_W-1:0]  remain_q;
    logic              accept;

    assign accept = start_i && (state_q == PH_IDLE) && (start_count_i != '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:      if (accept)     state_d = PH_CTRL_HI;
            PH_CTRL_HI:   if (eng_done_i) state_d = PH_ADDR_HI;
            PH_ADDR_HI:   if (eng_done_i) state_d = PH_CTRL_LO;
            PH_CTRL_LO:   if (eng_done_i) state_d = PH_ADDR_LO;
            PH_ADDR_LO:   if (eng_done_i) state_d = PH_DATA_WAIT;
            PH_DATA_WAIT: if (in_valid_i && eng_idle_i) state_d = PH_DATA_BUS;
            PH_DATA_BUS: begin
                if (eng_done_i) state_d = (remain_q == CNT_ONE) ? PH_DONE : PH_DATA_WAIT;
            end
            PH_DONE:      state_d = PH_IDLE;
            default:      state_d = PH_IDLE;
        endcase
    end

    // State and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            addr_q   <= '0;
            ctrl_q   <= '0;
            setup_q  <= '0;
            pulse_q  <= '0;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q   <= start_addr_i;
                ctrl_q   <= ctrl_word_i;
                setup_q  <= setup_cyc_i;
                pulse_q  <= pulse_cyc_i;
                remain_q <= start_count_i;
            end else if (state_q == PH_DATA_BUS && eng_done_i) begin
                remain_q <= remain_q - CNT_ONE;
            end
        end
    end

    // Outputs
    always_comb begin
        go_o       = 1'b0;
        sel_o      = SEL_CTRL;
        wdata_o    = ctrl_q;
        in_ready_o = 1'b0;
        unique case (state_q)
            PH_CTRL_HI, PH_CTRL_LO: begin
                go_o    = eng_idle_i;
                sel_o   = SEL_CTRL;
                wdata_o = ctrl_q;
            end
            PH_ADDR_HI: begin
                go_o    = eng_idle_i;
                sel_o   = SEL_ADDR;
                wdata_o = addr_q[ADDR_W-1:HALF_W];
            end
            PH_ADDR_LO: begin
                go_o    = eng_idle_i;
                sel_o   = SEL_ADDR;
                wdata_o = addr_q[HALF_W-1:0];
            end
            PH_DATA_WAIT: begin
                in_ready_o = eng_idle_i;
                go_o       = eng_idle_i && in_valid_i;
                sel_o      = SEL_DATA_INC;
                wdata_o    = in_data_i;
            end
            default: ;
        endcase
        busy_o  = (state_q != PH_IDLE);
        done_o  = (state_q == PH_DONE);
        setup_o = setup_q;
        pulse_o = pulse_q;
    end

    assert_done_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (remain_q == '0));

    assert_handshake_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !eng_idle_i);

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && state_q != PH_DONE) |=> (busy_o && $stable(remain_q) || eng_done_i));

endmodule

// File: rtl/hpi_write_seq.sv
module hpi_write_seq #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  start_count_i,
    input  logic [DATA_W-1:0] ctrl_word_i,
    input  logic [TIME_W-1:0] setup_cyc_i,
    input  logic [TIME_W-1:0] pulse_cyc_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              cs_n_o,
    output logic              we_n_o
);

    logic              eng_idle, eng_done, go;
    logic [1:0]        sel;
    logic [DATA_W-1:0] wdata;
    logic [TIME_W-1:0] setup_l, pulse_l;

    hpi_phase_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .TIME_W (TIME_W)
    ) i_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_addr_i  (start_addr_i),
        .start_count_i (start_count_i),
        .ctrl_word_i   (ctrl_word_i),
        .setup_cyc_i   (setup_cyc_i),
        .pulse_cyc_i   (pulse_cyc_i),
        .in_data_i     (in_data_i),
        .in_valid_i    (in_valid_i),
        .in_ready_o    (in_ready_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .eng_idle_i    (eng_idle),
        .eng_done_i    (eng_done),
        .go_o          (go),
        .sel_o         (sel),
        .wdata_o       (wdata),
        .setup_o       (setup_l),
        .pulse_o       (pulse_l)
    );

    hpi_bus_cycle #(
        .DATA_W (DATA_W),
        .TIME_W (TIME_W)
    ) i_cycle (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .sel_i       (sel),
        .wdata_i     (wdata),
        .setup_cyc_i (setup_l),
        .pulse_cyc_i (pulse_l),
        .bus_addr_o  (bus_addr_o),
        .bus_data_o  (bus_data_o),
        .cs_n_o      (cs_n_o),
        .we_n_o      (we_n_o),
        .idle_o      (eng_idle),
        .cyc_done_o  (eng_done)
    );

endmodule

// File: tb/test_hpi_write_seq.sv
module test_hpi_write_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [15:0] start_count_i = '0;
    logic [15:0] ctrl_word_i = '0;
    logic [3:0]  setup_cyc_i = '0;
    logic [3:0]  pulse_cyc_i = '0;
    logic [15:0] in_data_i;
    logic        in_valid_i;
    logic        in_ready_o, busy_o, done_o, cs_n_o, we_n_o;
    logic [2:0]  bus_addr_o;
    logic [15:0] bus_data_o;

    always #2.5 clk = ~clk;

    hpi_write_seq i_hpi_write_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .start_count_i(start_count_i), .ctrl_word_i(ctrl_word_i),
        .setup_cyc_i(setup_cyc_i), .pulse_cyc_i(pulse_cyc_i),
        .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .busy_o(busy_o), .done_o(done_o), .bus_addr_o(bus_addr_o),
        .bus_data_o(bus_data_o), .cs_n_o(cs_n_o), .we_n_o(we_n_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Word stream source
    logic [15:0] feed_n = '0;
    logic [15:0] feed_base = '0;
    bit          stall_en = 1'b0;
    logic [15:0] idx = '0;
    logic [3:0]  phase_cnt = '0;

    function automatic logic [15:0] word_at(input logic [15:0] base, input logic [15:0] i);
        return (base ^ (i * 16'h0101)) + i;
    endfunction

    assign in_valid_i = (idx < feed_n) && (!stall_en || phase_cnt[1]);
    assign in_data_i  = word_at(feed_base, idx);

    always @(posedge clk) begin
        phase_cnt <= phase_cnt + 4'd1;
        if (start_i && !busy_o) idx <= '0;
        else if (in_valid_i && in_ready_o) idx <= idx + 16'd1;
    end

    // Bus monitor, sampled on the falling edge
    logic [2:0]  log_addr [64];
    logic [15:0] log_data [64];
    int          log_pulse [64];
    int          log_gap [64];
    int n_log = 0, done_cnt = 0, hold_err = 0, strobe_err = 0, ready_err = 0;
    int hs_cnt = 0, log_at_done = 0, high_run = 0, low_run = 0;
    bit prev_we = 1'b1, prev_busy = 1'b0;
    logic [2:0]  cap_addr;
    logic [15:0] cap_data;

    always @(negedge clk) begin
        if (busy_o && !prev_busy) begin
            n_log = 0; done_cnt = 0; hold_err = 0; strobe_err = 0;
            ready_err = 0; hs_cnt = 0; high_run = 0; log_at_done = 0;
        end
        if (in_ready_o && !cs_n_o) ready_err++;
        if (in_valid_i && in_ready_o) hs_cnt++;
        if (cs_n_o != we_n_o) strobe_err++;
        if (done_o) begin done_cnt++; log_at_done = n_log; end
        if (!we_n_o && prev_we) begin
            cap_addr = bus_addr_o; cap_data = bus_data_o;
            if (n_log < 64) log_gap[n_log] = high_run;
            high_run = 0; low_run = 1;
        end else if (!we_n_o) begin
            low_run++;
            if (bus_addr_o != cap_addr || bus_data_o != cap_data) strobe_err++;
        end else if (we_n_o && !prev_we) begin
            if (bus_addr_o != cap_addr || bus_data_o != cap_data) hold_err++;
            if (n_log < 64) begin
                log_addr[n_log] = cap_addr; log_data[n_log] = cap_data;
                log_pulse[n_log] = low_run;
            end
            n_log++;
            if (busy_o) high_run = 1;
        end else if (busy_o) begin
            high_run++;
        end
        prev_we = we_n_o;
        prev_busy = busy_o;
    end

    task automatic wait_end(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (!busy_o && done_cnt > 0) begin ok = 1'b1; break; end
        end
    endtask

    // One full sequence with checks
    task automatic run_seq(input logic [31:0] a, input logic [15:0] n, input logic [15:0] cw,
                           input logic [3:0] s, input logic [3:0] p, input bit stall,
                           input bit poke_busy, input bit change_cfg, input string tag);
        int es, ep;
        bit ok;
        es = (s == 0) ? 1 : int'(s);
        ep = (p == 0) ? 1 : int'(p);
        feed_n = n; feed_base = a[15:0] ^ 16'h5A3C; stall_en = stall;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; start_count_i = n; ctrl_word_i = cw;
        setup_cyc_i = s; pulse_cyc_i = p;
        @(negedge clk);
        start_i = 1'b0;
        if (change_cfg) begin
            start_addr_i = ~a; ctrl_word_i = ~cw; start_count_i = n + 16'd3;
            setup_cyc_i = s + 4'd2; pulse_cyc_i = p + 4'd1;
        end
        if (poke_busy) begin
            repeat (9) @(negedge clk);
            start_i = 1'b1; start_addr_i = 32'hDEAD_BEEF; start_count_i = 16'd2;
            ctrl_word_i = 16'h7777;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_end(ok);
        chk(ok, {tag, " R9 sequence ends"}, 32'(ok), 1);
        chk(n_log == int'(n) + 4, {tag, " R4 write count"}, n_log, int'(n) + 4);
        if (n_log == int'(n) + 4 && n_log <= 64) begin
            // R3 setup order and R2 codes
            chk(log_addr[0] == 3'b000 && log_data[0] == cw, {tag, " R3/R5 first ctrl"}, {13'd0, log_addr[0], log_data[0]}, {16'd0, cw});
            chk(log_addr[1] == 3'b100 && log_data[1] == a[31:16], {tag, " R3 addr hi"}, {13'd0, log_addr[1], log_data[1]}, {13'd0, 3'b100, a[31:16]});
            chk(log_addr[2] == 3'b000 && log_data[2] == cw, {tag, " R3 second ctrl"}, {13'd0, log_addr[2], log_data[2]}, {16'd0, cw});
            chk(log_addr[3] == 3'b100 && log_data[3] == a[15:0], {tag, " R3 addr lo"}, {13'd0, log_addr[3], log_data[3]}, {13'd0, 3'b100, a[15:0]});
            chk(log_gap[0] == es + 1, {tag, " R6 first setup"}, log_gap[0], es + 1);
            for (int k = 0; k < n_log; k++) begin
                if (k >= 4) begin
                    logic [15:0] w;
                    w = word_at(feed_base, 16'(k - 4));
                    chk(log_addr[k] == 3'b010 && log_data[k] == w, {tag, " R4 data word"}, {13'd0, log_addr[k], log_data[k]}, {13'd0, 3'b010, w});
                end
                chk(log_pulse[k] == ep, {tag, " R7 strobe width"}, log_pulse[k], ep);
                if (k > 0) begin
                    if (stall) chk(log_gap[k] >= es + 2, {tag, " R6 setup gap"}, log_gap[k], es + 2);
                    else       chk(log_gap[k] == es + 2, {tag, " R6 setup gap"}, log_gap[k], es + 2);
                end
            end
        end
        chk(strobe_err == 0, {tag, " R7 strobe stable"}, strobe_err, 0);
        chk(hold_err == 0, {tag, " R8 hold stable"}, hold_err, 0);
        chk(done_cnt == 1, {tag, " R9 done width"}, done_cnt, 1);
        chk(log_at_done == int'(n) + 4, {tag, " R9 done after last"}, log_at_done, int'(n) + 4);
        chk(hs_cnt == int'(n), {tag, " R12 handshakes"}, hs_cnt, int'(n));
        chk(ready_err == 0, {tag, " R12 ready only idle"}, ready_err, 0);
        chk(!busy_o && cs_n_o, {tag, " R9 idle after"}, {busy_o, cs_n_o}, 1);
        feed_n = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(cs_n_o && we_n_o && !busy_o && !done_o && !in_ready_o, "R1 in reset",
            {cs_n_o, we_n_o, busy_o, done_o, in_ready_o}, 5'b11000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o && we_n_o && !busy_o && !done_o && !in_ready_o, "R1 after reset",
            {cs_n_o, we_n_o, busy_o, done_o, in_ready_o}, 5'b11000);
    endtask

    task automatic t_zero_count;
        int seen;
        seen = 0;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'h1111_2222; start_count_i = 16'd0;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (busy_o || !cs_n_o || !we_n_o) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R11 zero count ignored", seen, 0);
    endtask

    initial begin
        t_reset();
        run_seq(32'h0012_3456, 16'd3, 16'h0009, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0, "basic");
        run_seq(32'hA5C3_0F0F, 16'd2, 16'h0102, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, "latch R5");
        run_seq(32'h00FE_8001, 16'd4, 16'h0033, 4'd1, 4'd2, 1'b0, 1'b1, 1'b0, "busy start R10");
        t_zero_count();
        run_seq(32'h7FFF_0000, 16'd40, 16'h0001, 4'd1, 4'd2, 1'b0, 1'b0, 1'b0, "long");
        run_seq(32'h0000_FFFF, 16'd1, 16'hFFFF, 4'd15, 4'd15, 1'b1, 1'b0, 1'b0, "max timing");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule